// File: doc/BRIEF.md
# SMBus Block-Read Responder with Packet Error Code

This block is the byte-level engine that answers an SMBus block read. A bit-level front end samples the clock and data lines. It hands this engine decoded events: a start or repeated start, a stop, a complete received byte, and the master's acknowledge or not-acknowledge after each byte the slave sends. The engine checks the write half of the transaction, which carries its own address and a command code. It then checks a repeated start and a read of its own address. After that it presents, one at a time, the bytes for the front end to shift out: a byte count, a block of data bytes fetched from a register file, and a packet error code.

Each accepted command code selects one block of the register file. Code `CMD_BASE + n` reads register addresses `n*BLK_LEN` up to `n*BLK_LEN + BLK_LEN - 1`. The packet error code is a CRC-8 that is recomputed on every transaction. It starts from zero and takes in each byte in the order it appears on the bus. The engine can be aborted at any point by a stop or by a start that it does not expect.

Top module: `smbus_blkrd_pec`

## Requirements
- R1: A received byte equal to `{OWN_ADDR, 0}` in the first byte after a start is acknowledged. Any other value there is not acknowledged, and the engine stays idle until the next start.
- R2: A command code in range is acknowledged while `busy` is low. While `busy` is high it is not acknowledged, and the engine goes idle.
- R3: A command code outside `CMD_BASE` up to `CMD_BASE + NUM_BLOCKS - 1` is not acknowledged, and the engine goes idle.
- R4: After an acknowledged command, a repeated start followed by `{OWN_ADDR, 1}` is acknowledged. Any other address byte there is not acknowledged.
- R5: On the second clock edge after the read address is received, `tx_load` pulses and `tx_byte` holds the byte count `BLK_LEN` (16).
- R6: Each master acknowledge of the count, or of data byte k-1, makes `tx_load` pulse one cycle later. `tx_byte` then holds the register at `rf_addr = (cmd - CMD_BASE)*BLK_LEN + k`, for k = 0 to 15.
- R7: The master acknowledge of the last data byte loads the PEC byte one cycle later. It is the CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, processed MSB first. It covers, in order, the write address, the command, the read address, the count and all data bytes.
- R8: After a master not-acknowledge of any sent byte, including the PEC, `tx_load` stays low for every later master response until a stop or a start.
- R9: A stop in any state returns the engine to idle. A start outside the repeated-start point aborts the transaction, clears the CRC and treats the next byte as a write address.
- R10: `slv_ack_valid` pulses exactly one cycle after `rx_valid`, and only for the write address, command and read address bytes. `slv_ack` is 1 for ACK and 0 for NACK. Bytes received in other states produce no pulse. Both `slv_ack_valid` and `tx_load` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Pulse: start or repeated start detected |
| bus_stop | input | 1 | Pulse: stop detected |
| rx_valid | input | 1 | Pulse: a byte from the master is complete |
| rx_byte | input | 8 | The received byte, valid with `rx_valid` |
| mack_valid | input | 1 | Pulse: master response to a sent byte |
| mack_nack | input | 1 | With `mack_valid`: 1 = NACK, 0 = ACK |
| busy | input | 1 | Command codes are refused while high |
| slv_ack_valid | output | 1 | Pulse: acknowledge decision for the last received byte |
| slv_ack | output | 1 | 1 = drive ACK, 0 = NACK |
| tx_load | output | 1 | Pulse: `tx_byte` holds a new byte to send |
| tx_byte | output | 8 | Byte to send next |
| rf_addr | output | RF_AW | Register file read address |
| rf_rdata | input | 8 | Register file data for `rf_addr`, combinational |

## Verification
Assertions in the RTL watch several rules on every cycle: each acknowledge decision follows a received byte, a busy engine refuses a command, a stop forces idle, the CRC register clears when asked and otherwise holds, the data index stays inside the block, and the command decoder never matches two blocks. The values on the bus can only be shown by the bench's scenarios. These are the count byte, the exact bytes fetched from each block, the PEC after a full transfer, and silence after an early master NACK. Recovery after an abort also needs the bench, and the PEC of a complete transfer that follows a mid-transfer start is what shows the CRC was cleared.

// File: rtl/smbr_pkg.sv
// Shared types and the CRC-8 step used by the block-read engine.
// Assumes: bytes are sent MSB first; CRC polynomial 0x07, no reflection.
package smbr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_W,
        ST_CMD,
        ST_WAIT_RS,
        ST_ADDR_R,
        ST_CNT_LD,
        ST_SEND_CNT,
        ST_SEND_DATA,
        ST_SEND_PEC,
        ST_WAIT_STOP
    } smbr_state_e;

    localparam logic [7:0] CRC_POLY = 8'h07;

    // One byte through the CRC-8 shift register, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ CRC_POLY;
            else             r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/smbr_crc8.sv
// Running CRC-8 register for the packet error code.
// Assumes: clr has priority over en; en folds din in one cycle.
module smbr_crc8
    import smbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);

    // Accumulate one byte per enabled cycle; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= 8'h00;
        else if (clr) crc <= 8'h00;
        else if (en)  crc <= crc8_step(crc, din);
    end

    p_crc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == 8'h00));

    p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc));

endmodule

// File: rtl/smbr_decode.sv
// Address and command decoder for a received byte.
// Assumes: one block of BLK_LEN registers per accepted command code.
module smbr_decode #(
    parameter logic [6:0] OWN_ADDR   = 7'h2C,
    parameter logic [7:0] CMD_BASE   = 8'hB0,
    parameter int         NUM_BLOCKS = 4,
    parameter int         BLK_LEN    = 16,
    parameter int         RF_AW      = 6
) (
    input  logic [7:0]       rx_byte,
    output logic             addr_w_hit,
    output logic             addr_r_hit,
    output logic             cmd_hit,
    output logic [RF_AW-1:0] blk_base
);

    logic [NUM_BLOCKS-1:0] blk_hit;

    assign addr_w_hit = (rx_byte == {OWN_ADDR, 1'b0});
    assign addr_r_hit = (rx_byte == {OWN_ADDR, 1'b1});

    // One comparator per block command code.
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_cmd
        assign blk_hit[g] = (rx_byte == 8'(int'(CMD_BASE) + g));
    end

    assign cmd_hit = |blk_hit;

    // Start address of the selected block.
    always_comb begin
        blk_base = '0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (blk_hit[i]) blk_base = blk_base | RF_AW'(i * BLK_LEN);
        end
    end

    // R3: at most one command code can match.
    always_comb begin
        p_cmd_onehot_r3: assert ($onehot0(blk_hit));
    end

endmodule

// File: rtl/smbr_seq.sv
// Transaction sequencer: accepts the write phase, the repeated start and the read address,
// then presents the count, the data block and the PEC, one byte per master ACK.
// Assumes: event pulses last one cycle; stop beats start, and both beat byte events.
module smbr_seq
    import smbr_pkg::*;
#(
    parameter int BLK_LEN = 16,
    parameter int RF_AW   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             mack_valid,
    input  logic             mack_nack,
    input  logic             busy,
    input  logic             addr_w_hit,
    input  logic             addr_r_hit,
    input  logic             cmd_hit,
    input  logic [RF_AW-1:0] blk_base,
    input  logic [7:0]       crc_val,
    input  logic [7:0]       rf_rdata,
    output logic             crc_clr,
    output logic             crc_en,
    output logic [7:0]       crc_din,
    output logic             slv_ack_valid,
    output logic             slv_ack,
    output logic             tx_load,
    output logic [7:0]       tx_byte,
    output logic [RF_AW-1:0] rf_addr
);

    localparam int         CNT_W    = $clog2(BLK_LEN + 1);
    localparam logic [7:0] CNT_BYTE = 8'(BLK_LEN);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLK_LEN);

    smbr_state_e      state, nxt;
    logic [CNT_W-1:0] idx, idx_n;
    logic [RF_AW-1:0] base_q, base_n;
    logic             ackv_n, ack_n, ld_n;
    logic [7:0]       txb_n;

    assign rf_addr = base_q + RF_AW'(idx);

    // Next state, responses and CRC feed for this cycle's event.
    always_comb begin
        nxt     = state;
        idx_n   = idx;
        base_n  = base_q;
        ackv_n  = 1'b0;
        ack_n   = 1'b0;
        ld_n    = 1'b0;
        txb_n   = tx_byte;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        crc_din = rx_byte;
        if (bus_stop) begin
            nxt     = ST_IDLE;
            crc_clr = 1'b1;
        end else if (bus_start) begin
            if (state == ST_WAIT_RS) begin
                nxt = ST_ADDR_R;
            end else begin
                nxt     = ST_ADDR_W;
                crc_clr = 1'b1;
            end
        end else begin
            unique case (state)
                ST_ADDR_W: if (rx_valid) begin
                    ackv_n = 1'b1;
                    if (addr_w_hit) begin
                        ack_n  = 1'b1;
                        crc_en = 1'b1;
                        nxt    = ST_CMD;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_CMD: if (rx_valid) begin
                    ackv_n = 1'b1;
                    if (cmd_hit && !busy) begin
                        ack_n  = 1'b1;
                        crc_en = 1'b1;
                        base_n = blk_base;
                        nxt    = ST_WAIT_RS;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_WAIT_RS: if (rx_valid) nxt = ST_IDLE;
                ST_ADDR_R: if (rx_valid) begin
                    ackv_n = 1'b1;
                    if (addr_r_hit) begin
                        ack_n  = 1'b1;
                        crc_en = 1'b1;
                        idx_n  = '0;
                        nxt    = ST_CNT_LD;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_CNT_LD: begin
                    ld_n    = 1'b1;
                    txb_n   = CNT_BYTE;
                    crc_en  = 1'b1;
                    crc_din = CNT_BYTE;
                    nxt     = ST_SEND_CNT;
                end
                ST_SEND_CNT, ST_SEND_DATA: if (mack_valid) begin
                    if (mack_nack) begin
                        nxt = ST_WAIT_STOP;
                    end else if (idx == LAST_IDX) begin
                        ld_n  = 1'b1;
                        txb_n = crc_val;
                        nxt   = ST_SEND_PEC;
                    end else begin
                        ld_n    = 1'b1;
                        txb_n   = rf_rdata;
                        crc_en  = 1'b1;
                        crc_din = rf_rdata;
                        idx_n   = idx + 1'b1;
                        nxt     = ST_SEND_DATA;
                    end
                end
                ST_SEND_PEC: if (mack_valid) nxt = ST_WAIT_STOP;
                default: ;
            endcase
        end
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            idx           <= '0;
            base_q        <= '0;
            slv_ack_valid <= 1'b0;
            slv_ack       <= 1'b0;
            tx_load       <= 1'b0;
            tx_byte       <= 8'h00;
        end else begin
            state         <= nxt;
            idx           <= idx_n;
            base_q        <= base_n;
            slv_ack_valid <= ackv_n;
            slv_ack       <= ack_n;
            tx_load       <= ld_n;
            tx_byte       <= txb_n;
        end
    end

    p_ack_after_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ack_valid |-> $past(rx_valid));

    p_busy_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && rx_valid && busy && !bus_start && !bus_stop)
        |=> (slv_ack_valid && !slv_ack));

    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (state == ST_IDLE));

    p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);

    p_quiet_after_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_STOP) |-> !tx_load);

    p_count_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CNT_LD) |=> (tx_load && tx_byte == CNT_BYTE));

endmodule

// File: rtl/smbus_blkrd_pec.sv
// Top of the SMBus block-read responder: decoder, sequencer and PEC register.
// Assumes: a bit-level front end supplies decoded bus events and shifts tx_byte out.
module smbus_blkrd_pec #(
    parameter logic [6:0] OWN_ADDR   = 7'h2C,
    parameter logic [7:0] CMD_BASE   = 8'hB0,
    parameter int         NUM_BLOCKS = 4,
    parameter int         BLK_LEN    = 16,
    parameter int         RF_AW      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             mack_valid,
    input  logic             mack_nack,
    input  logic             busy,
    output logic             slv_ack_valid,
    output logic             slv_ack,
    output logic             tx_load,
    output logic [7:0]       tx_byte,
    output logic [RF_AW-1:0] rf_addr,
    input  logic [7:0]       rf_rdata
);

    logic             addr_w_hit, addr_r_hit, cmd_hit;
    logic [RF_AW-1:0] blk_base;
    logic             crc_clr, crc_en;
    logic [7:0]       crc_din, crc_val;

    smbr_decode #(
        .OWN_ADDR(OWN_ADDR), .CMD_BASE(CMD_BASE), .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_LEN(BLK_LEN), .RF_AW(RF_AW)
    ) u_dec (
        .rx_byte(rx_byte), .addr_w_hit(addr_w_hit), .addr_r_hit(addr_r_hit),
        .cmd_hit(cmd_hit), .blk_base(blk_base)
    );

    smbr_crc8 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
        .din(crc_din), .crc(crc_val)
    );

    smbr_seq #(.BLK_LEN(BLK_LEN), .RF_AW(RF_AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .mack_valid(mack_valid),
        .mack_nack(mack_nack), .busy(busy), .addr_w_hit(addr_w_hit),
        .addr_r_hit(addr_r_hit), .cmd_hit(cmd_hit), .blk_base(blk_base),
        .crc_val(crc_val), .rf_rdata(rf_rdata), .crc_clr(crc_clr),
        .crc_en(crc_en), .crc_din(crc_din), .slv_ack_valid(slv_ack_valid),
        .slv_ack(slv_ack), .tx_load(tx_load), .tx_byte(tx_byte), .rf_addr(rf_addr)
    );

endmodule

// File: tb/smbus_blkrd_pec_test.sv
// Directed bench: one task per scenario; inputs change and outputs are sampled on falling edges.
module smbus_blkrd_pec_test;

    localparam logic [6:0] ADDR = 7'h2C;
    localparam logic [7:0] CMDB = 8'hB0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       mack_valid = 1'b0, mack_nack = 1'b0, busy = 1'b0;
    logic       slv_ack_valid, slv_ack, tx_load;
    logic [7:0] tx_byte, rf_rdata;
    logic [5:0] rf_addr;
    int         n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] rf_model(input logic [5:0] a);
        return (8'(a) * 8'd7) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] pec_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    assign rf_rdata = rf_model(rf_addr);

    smbus_blkrd_pec uut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .mack_valid(mack_valid),
        .mack_nack(mack_nack), .busy(busy), .slv_ack_valid(slv_ack_valid),
        .slv_ack(slv_ack), .tx_load(tx_load), .tx_byte(tx_byte),
        .rf_addr(rf_addr), .rf_rdata(rf_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ev_start();
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic ev_stop();
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, output logic [7:0] resp);
        rx_byte = b; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
        resp = {6'b0, slv_ack_valid, slv_ack};
    endtask

    task automatic mst(input logic nk, output logic ld, output logic [7:0] tb);
        mack_valid = 1'b1; mack_nack = nk; @(negedge clk);
        mack_valid = 1'b0; mack_nack = 1'b0;
        ld = tx_load; tb = tx_byte;
    endtask

    // Full or truncated block read; nack_after = data bytes loaded before the master NACKs.
    task automatic do_read(input logic [7:0] cmd, input int nack_after);
        logic [7:0] r, tb, crc, exp;
        logic       ld;
        int         base;
        crc  = 8'h00;
        base = int'(cmd - CMDB) * 16;
        ev_start();
        send({ADDR, 1'b0}, r); chk("R1 write address ACK", r, 8'h03);
        crc = pec_step(crc, {ADDR, 1'b0});
        send(cmd, r); chk("R2 command ACK", r, 8'h03);
        crc = pec_step(crc, cmd);
        ev_start();
        send({ADDR, 1'b1}, r); chk("R4 read address ACK", r, 8'h03);
        crc = pec_step(crc, {ADDR, 1'b1});
        @(negedge clk);
        chk("R5 count load", {7'b0, tx_load}, 8'h01);
        chk("R5 count value", tx_byte, 8'd16);
        crc = pec_step(crc, 8'd16);
        for (int k = 0; k <= 16; k++) begin
            if (k == nack_after && k < 16) begin
                mst(1'b1, ld, tb); chk("R8 no load after NACK", {7'b0, ld}, 8'h00);
                mst(1'b0, ld, tb); chk("R8 no load after later ACK", {7'b0, ld}, 8'h00);
                ev_stop();
                return;
            end
            mst(1'b0, ld, tb);
            if (k < 16) begin
                exp = rf_model(6'(base + k));
                chk("R6 data load", {7'b0, ld}, 8'h01);
                chk("R6 data value", tb, exp);
                crc = pec_step(crc, exp);
            end else begin
                chk("R7 PEC load", {7'b0, ld}, 8'h01);
                chk("R7 PEC value", tb, crc);
            end
        end
        mst(1'b1, ld, tb); chk("R8 nothing after PEC NACK", {7'b0, ld}, 8'h00);
        ev_stop();
    endtask

    task automatic t_reset();
        chk("R10 reset ack idle", {7'b0, slv_ack_valid}, 8'h00);
        chk("R10 reset tx idle", {7'b0, tx_load}, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] r;
        ev_start();
        send({ADDR, 1'b0}, r); chk("R1 ACK before busy", r, 8'h03);
        busy = 1'b1;
        send(CMDB, r); chk("R2 busy NACK", r, 8'h02);
        busy = 1'b0;
        ev_start();
        send({ADDR, 1'b1}, r); chk("R2 idle after busy NACK", r, 8'h02);
        @(negedge clk); chk("R2 no count after busy", {7'b0, tx_load}, 8'h00);
        ev_stop();
    endtask

    task automatic t_bad_cmd();
        logic [7:0] r;
        ev_start(); send({ADDR, 1'b0}, r);
        send(CMDB + 8'd4, r); chk("R3 above range NACK", r, 8'h02);
        ev_start(); send({ADDR, 1'b0}, r);
        send(CMDB - 8'd1, r); chk("R3 below range NACK", r, 8'h02);
        ev_stop();
    endtask

    task automatic t_bad_addr();
        logic [7:0] r;
        ev_start();
        send({7'h2D, 1'b0}, r); chk("R1 foreign address NACK", r, 8'h02);
        send(CMDB, r); chk("R10 no response when idle", r, 8'h00);
        ev_stop();
        ev_start(); send({ADDR, 1'b0}, r); send(CMDB, r);
        send(8'h55, r); chk("R10 no response awaiting restart", r, 8'h00);
        ev_stop();
    endtask

    task automatic t_bad_read_addr();
        logic [7:0] r;
        ev_start(); send({ADDR, 1'b0}, r); send(CMDB + 8'd1, r);
        ev_start();
        send({ADDR, 1'b0}, r); chk("R4 read phase wrong direction NACK", r, 8'h02);
        ev_stop();
    endtask

    task automatic t_stop_mid();
        logic [7:0] r;
        ev_start(); send({ADDR, 1'b0}, r); send(CMDB, r);
        ev_stop();
        ev_start();
        send({ADDR, 1'b1}, r); chk("R9 stop drops pending restart", r, 8'h02);
        ev_stop();
    endtask

    // R9: abort mid-data with a start, then a full read must produce a correct PEC.
    task automatic t_abort();
        logic [7:0] r, tb;
        logic       ld;
        ev_start(); send({ADDR, 1'b0}, r); send(CMDB + 8'd1, r);
        ev_start(); send({ADDR, 1'b1}, r);
        @(negedge clk);
        mst(1'b0, ld, tb); mst(1'b0, ld, tb); mst(1'b0, ld, tb);
        do_read(CMDB + 8'd2, 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        do_read(CMDB, 16);
        do_read(CMDB + 8'd3, 16);
        t_busy();
        t_bad_cmd();
        t_bad_addr();
        t_bad_read_addr();
        do_read(CMDB + 8'd1, 3);
        do_read(CMDB, 0);
        t_stop_mid();
        t_abort();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule